// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block raises a one-cycle interrupt pulse at a steady, software-chosen rate. A 10-bit reload value, called the period value below, sets the number of ticks between pulses. The divisor is the period value plus one. Software writes this value through a small byte-wide register port. The lower eight bits have a write-only slot of their own. The upper two bits share a read/write control byte with a run/stop bit and a 2-bit tick-source select.

The counter does not step on every system clock. It steps only on a tick, which is a single-cycle enable synchronous to the system clock. A tick comes from one of two external tick inputs or from an internal tick. The internal tick is made by dividing the system clock by 143, which gives roughly 100 kHz from a 14.318 MHz crystal. A down-counter reloads from the period value on each expiry and emits the pulse. The pulse goes to an interrupt controller outside this block.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset, or while `rst_n` is low, both register addresses read 0x00, `irq_pulse` is 0, the timer is stopped and the source select is 00.
- R2: Address 0 (period low byte) always reads 0x00. Address 1 (control) reads RUN in bit 7, the source select in bits 6:5 and period bits 9:8 in bits 1:0. Bits 4:2 read 0, and writes to them are dropped.
- R3: While running with period value N, `irq_pulse` fires once every N+1 ticks of the selected source. The first pulse comes on the (N+1)th tick after RUN is set.
- R4: `irq_pulse` goes high for exactly one system clock. It is high in the cycle right after the clock edge that sampled the expiring tick.
- R5: A period value of 0 gives one pulse for every selected tick.
- R6: Source select 00 counts ticks on `tick_ext_a` and 01 counts ticks on `tick_ext_b`. Ticks on the input that is not selected have no effect.
- R7: Source select 10 supplies no ticks, so `irq_pulse` stays 0 whatever the tick inputs do.
- R8: Source select 11 counts the internal tick, which comes once every 143 system clocks. With a period value of 0, pulses are exactly 143 clocks apart.
- R9: While RUN is 0 the count is frozen and no pulse is produced, whatever the tick inputs do.
- R10: When RUN goes from 0 to 1, the counter reloads from the period value, so a partial count made before the stop is discarded.
- R11: The period value uses all 10 bits: the low byte from address 0 and bits 9:8 from the control byte. For example, a value of 261 gives one pulse per 262 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | Register select: 0 = period low byte, 1 = control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational, no side effects |
| tick_ext_a | input | 1 | External tick source A (select 00), single-cycle enable |
| tick_ext_b | input | 1 | External tick source B (select 01), single-cycle enable |
| irq_pulse | output | 1 | One-cycle interrupt pulse at each expiry |

## Verification
The assertions assume that the tick inputs are already synchronous single-cycle enables. They also assume that the period value is not rewritten in the same clock edge as a reload. The single-pulse property is checked only when the loaded count is non-zero, because a period value of 0 with a tick on every cycle would legitimately hold the output high. The bench keeps to these limits. It drives every tick and write at the falling edge, for exactly one cycle. It stops the timer before changing the period value. It separates writes from the ticks that follow them by at least two idle cycles.

// File: rtl/pit_pkg.sv
// pit_pkg: shared constants and types for the periodic interrupt timer.
// Assumes a one-bit register address and a byte-wide data path.
package pit_pkg;

    // Tick source select codes held in the control byte.
    typedef enum logic [1:0] {
        SRC_EXT_A    = 2'b00,
        SRC_EXT_B    = 2'b01,
        SRC_NONE     = 2'b10,
        SRC_INTERNAL = 2'b11
    } tick_src_e;

    // Register addresses.
    localparam logic ADDR_PERIOD_LO = 1'b0;
    localparam logic ADDR_CTRL      = 1'b1;

    // Bit positions in the control byte; readback depends on them.
    localparam int CTRL_RUN_BIT = 7;
    localparam int CTRL_SEL_LSB = 5;
    localparam int SEL_W        = 2;

endpackage

// File: rtl/pit_regs.sv
// pit_regs: holds the period value, the run bit and the tick-source select.
// The low period byte can be written but not read back (reads give zero).
// The control byte can be read back. Reads are combinational on the address.
// Assumes DATA_W < CNT_W <= 2*DATA_W and that the upper period bits fit below the select field.
module pit_regs
    import pit_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  reload,
    output logic              run,
    output tick_src_e         sel
);

    localparam int HI_W = CNT_W - DATA_W;

    logic [DATA_W-1:0] period_lo;
    logic [HI_W-1:0]   period_hi;
    logic              unused_rsvd;

    // Capture register writes; reset clears every field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_lo <= '0;
            period_hi <= '0;
            run       <= 1'b0;
            sel       <= SRC_EXT_A;
        end else if (wr_en) begin
            if (addr == ADDR_PERIOD_LO) begin
                period_lo <= wr_data;
            end else begin
                run       <= wr_data[CTRL_RUN_BIT];
                sel       <= tick_src_e'(wr_data[CTRL_SEL_LSB +: SEL_W]);
                period_hi <= wr_data[HI_W-1:0];
            end
        end
    end

    // Reserved control bits are dropped.
    assign unused_rsvd = ^wr_data[CTRL_SEL_LSB-1:HI_W];

    // Assemble the full period value for the counter.
    assign reload = {period_hi, period_lo};

    // Readback mux: the low byte reads zero, the control byte reads its fields.
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_CTRL) begin
            rd_data[CTRL_RUN_BIT]              = run;
            rd_data[CTRL_SEL_LSB +: SEL_W]     = sel;
            rd_data[HI_W-1:0]                  = period_hi;
        end
    end

endmodule

// File: rtl/pit_prescaler.sv
// pit_prescaler: free-running divider that emits a one-cycle internal tick
// every DIV system clocks. The first tick comes DIV clocks after reset.
// Assumes DIV >= 2.
module pit_prescaler #(
    parameter int DIV = 143
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick on the terminal count.
    assign tick = (cnt == LAST);

endmodule

// File: rtl/pit_tick_mux.sv
// pit_tick_mux: picks the tick that advances the counter.
// The reserved select code gives no tick at all.
// Assumes every tick input is a synchronous single-cycle enable.
module pit_tick_mux
    import pit_pkg::*;
(
    input  tick_src_e sel,
    input  logic      ext_a,
    input  logic      ext_b,
    input  logic      int_tick,
    output logic      tick
);

    // Decode the select into one enable.
    always_comb begin
        unique case (sel)
            SRC_EXT_A:    tick = ext_a;
            SRC_EXT_B:    tick = ext_b;
            SRC_INTERNAL: tick = int_tick;
            default:      tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/pit_counter.sv
// pit_counter: reloading down-counter. It loads the period value when run
// rises. It decrements on each tick while running. When a tick finds it at zero,
// it reloads and raises a one-cycle pulse.
// A period value change takes effect at the next reload.
module pit_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    logic run_d;

    // Track run, load on its rising edge, count ticks and flag expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            run_d <= 1'b0;
            irq   <= 1'b0;
        end else begin
            run_d <= run;
            irq   <= 1'b0;
            if (run && !run_d) begin
                count <= reload;
            end else if (run && tick) begin
                if (count == '0) begin
                    count <= reload;
                    irq   <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/periodic_irq_timer.sv
// periodic_irq_timer: top level. Joins the register file, the internal
// prescaler, the tick-source mux and the reloading counter.
// Assumes the external ticks are synchronous to clk.
module periodic_irq_timer
    import pit_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int DATA_W    = 8,
    parameter int PRESC_DIV = 143
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_ext_a,
    input  logic              tick_ext_b,
    output logic              irq_pulse
);

    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             run;
    tick_src_e        sel;
    logic             int_tick;
    logic             tick;

    pit_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .reload  (reload),
        .run     (run),
        .sel     (sel)
    );

    pit_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (int_tick)
    );

    pit_tick_mux u_mux (
        .sel      (sel),
        .ext_a    (tick_ext_a),
        .ext_b    (tick_ext_b),
        .int_tick (int_tick),
        .tick     (tick)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .reload (reload),
        .count  (count),
        .irq    (irq_pulse)
    );

endmodule

// File: rtl/pit_checker.sv
// pit_checker: temporal properties of the periodic interrupt timer,
// bound to the top level. The prescaler spacing is checked with a local counter.
module pit_checker
    import pit_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int DATA_W    = 8,
    parameter int PRESC_DIV = 143
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              run,
    input tick_src_e         sel,
    input logic              tick,
    input logic              int_tick,
    input logic [CNT_W-1:0]  reload,
    input logic [CNT_W-1:0]  count,
    input logic              irq_pulse
);

    localparam int GAP_W = $clog2(PRESC_DIV) + 1;

    logic [GAP_W-1:0] gap;

    // Clocks since the last internal tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        gap <= '0;
        else if (int_tick) gap <= '0;
        else               gap <= gap + 1'b1;
    end

    p_lo_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_PERIOD_LO) |-> (reg_rdata == '0));

    p_irq_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(tick) && $past(run)));

    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && count != '0) |=> !irq_pulse);

    p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel) == SRC_NONE) |-> !irq_pulse);

    p_presc_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_tick |-> (gap == GAP_W'(PRESC_DIV - 1)));

    p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !irq_pulse);

    p_start_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |=> (count == $past(reload)));

endmodule

bind periodic_irq_timer pit_checker #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .PRESC_DIV(PRESC_DIV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .run       (run),
    .sel       (sel),
    .tick      (tick),
    .int_tick  (int_tick),
    .reload    (reload),
    .count     (count),
    .irq_pulse (irq_pulse)
);

// File: tb/tb_periodic_irq_timer.sv
// Bench for periodic_irq_timer: one table-driven loop, then directed tests.
module tb_periodic_irq_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tick_ext_a = 1'b0;
    logic       tick_ext_b = 1'b0;
    logic       irq_pulse;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    periodic_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick_ext_a(tick_ext_a), .tick_ext_b(tick_ext_b), .irq_pulse(irq_pulse)
    );

    // Stimulus vector: select, period, which input gets ticks, idle gap, tick count, expected pulses.
    typedef struct packed {
        logic [1:0]  sel;
        logic [9:0]  period;
        logic        on_b;
        logic [3:0]  gap;
        logic [15:0] nticks;
        logic [15:0] exp_irq;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{2'b00, 10'd3,   1'b0, 4'd0, 16'd12,  16'd3},
        '{2'b00, 10'd0,   1'b0, 4'd2, 16'd5,   16'd5},
        '{2'b01, 10'd4,   1'b1, 4'd1, 16'd15,  16'd3},
        '{2'b01, 10'd2,   1'b0, 4'd0, 16'd9,   16'd0},
        '{2'b10, 10'd0,   1'b0, 4'd1, 16'd6,   16'd0},
        '{2'b00, 10'd261, 1'b0, 4'd0, 16'd524, 16'd2},
        '{2'b00, 10'd2,   1'b1, 4'd0, 16'd6,   16'd0}
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R3 R6";
            1: return "R5";
            2: return "R6 R3";
            3: return "R6";
            4: return "R7";
            5: return "R11";
            default: return "R6";
        endcase
    endfunction

    // Count pulses seen at falling edges.
    always @(negedge clk) if (irq_pulse === 1'b1) irq_seen++;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic pulses(logic on_b, int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (on_b) tick_ext_b = 1'b1; else tick_ext_a = 1'b1;
            @(negedge clk);
            tick_ext_a = 1'b0; tick_ext_b = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic setup(logic [1:0] sel, logic [9:0] per, logic go);
        wr(1'b1, 8'h00);
        wr(1'b0, per[7:0]);
        wr(1'b1, {go, sel, 3'b000, per[9:8]});
        repeat (2) @(negedge clk);
        irq_seen = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int c;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1 irq in reset", int'(irq_pulse), 0);
        rst_n = 1'b1;
        rd(1'b1, v); chk("R1 ctrl after reset", v, 0);
        rd(1'b0, v); chk("R1 low byte after reset", v, 0);
        chk("R1 irq after reset", int'(irq_pulse), 0);

        // R2: readback layout
        wr(1'b1, 8'hC1);
        rd(1'b1, v); chk("R2 ctrl readback", v, 8'hC1);
        wr(1'b1, 8'hFF);
        rd(1'b1, v); chk("R2 reserved bits dropped", v, 8'hE3);
        wr(1'b0, 8'hAB);
        rd(1'b0, v); chk("R2 low byte reads zero", v, 0);

        // Table loop
        for (int i = 0; i < NVEC; i++) begin
            setup(VEC[i].sel, VEC[i].period, 1'b1);
            pulses(VEC[i].on_b, int'(VEC[i].nticks), int'(VEC[i].gap));
            repeat (3) @(negedge clk);
            chk(vtag(i), irq_seen, int'(VEC[i].exp_irq));
        end

        // R4: pulse timing and width
        setup(2'b00, 10'd2, 1'b1);
        pulses(1'b0, 2, 3);
        chk("R4 no early pulse", int'(irq_pulse), 0);
        @(negedge clk); tick_ext_a = 1'b1;
        @(negedge clk); tick_ext_a = 1'b0;
        chk("R4 pulse one cycle after tick", int'(irq_pulse), 1);
        @(negedge clk);
        chk("R4 pulse lasts one cycle", int'(irq_pulse), 0);

        // R8: internal tick spacing
        setup(2'b11, 10'd0, 1'b1);
        c = 0;
        while (irq_pulse !== 1'b1 && c < 400) begin @(negedge clk); c++; end
        chk("R8 internal pulse seen", int'(irq_pulse === 1'b1), 1);
        c = 0;
        do begin @(negedge clk); c++; end while (irq_pulse !== 1'b1 && c < 400);
        chk("R8 internal pulse spacing", c, 143);

        // R9: stopped timer ignores ticks
        setup(2'b00, 10'd0, 1'b0);
        pulses(1'b0, 5, 0);
        repeat (3) @(negedge clk);
        chk("R9 no pulse while stopped", irq_seen, 0);
        rd(1'b1, v); chk("R9 ctrl shows stopped", v, 0);

        // R10: restart discards the partial count
        setup(2'b00, 10'd3, 1'b1);
        pulses(1'b0, 2, 0);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h80);
        repeat (2) @(negedge clk);
        irq_seen = 0;
        pulses(1'b0, 3, 0);
        repeat (2) @(negedge clk);
        chk("R10 no pulse before full period", irq_seen, 0);
        pulses(1'b0, 1, 0);
        repeat (2) @(negedge clk);
        chk("R10 pulse on fourth tick", irq_seen, 1);

        // R1: reset while running clears the control byte
        wr(1'b1, 8'hE3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        rd(1'b1, v); chk("R1 ctrl during reset", v, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule